// File: doc/BRIEF.md
# Bidirectional 64-bit Funnel Shifter

This unit performs one step of a multi-word shift. A 64-bit source word is shifted left or right by an amount taken from a second operand. The vacated bit positions are filled from a third word, called the fill word. The bits pushed out of the source come back on a separate spill output, so that a chain of these operations can pass them to the next word of a big integer. Both directions use a single rotator and a generated mask. The rotated source and the fill word are merged under that mask.

All results are registered and appear one clock after the operands are presented. An overflow bit reports whether any set bit was pushed out. When the record input is asserted, a 4-bit condition field is written with the sign class of the result and with the overflow bit. When the record input is clear, the condition field keeps its previous value.

Top module: `fsh_funnel`

## Requirements
- R1: The shift count n is bits [5:0] of `shamt_in`. Bits [63:6] of `shamt_in` have no effect on any output.
- R2: For a left shift (`dir_right`=0), `result` is `(src_in << n) | (fill_in & ((1<<n)-1))`. The low n bits therefore come from the fill word.
- R3: For a right shift (`dir_right`=1), `result` is `(src_in >> n) | (fill_in & ~(all-ones >> n))`. The high n bits therefore come from the fill word.
- R4: For a left shift, `spill` holds the top n bits of `src_in` in its low n positions. For a right shift, `spill` holds the low n bits of `src_in` in its top n positions. All other spill bits are zero.
- R5: `ovf` is 1 exactly when `spill` is nonzero.
- R6: When `rec_en` is 1, `cond` is updated with these bits: [3] set when result bit 63 is 1, [2] set when the result is nonzero and bit 63 is 0, [1] set when the result is zero, and [0] equal to `ovf`.
- R7: When `rec_en` is 0, `cond` keeps its previous value.
- R8: With n=0, in either direction, `result` equals `src_in`, `spill` is zero and `ovf` is 0.
- R9: The outputs change one clock after the inputs are sampled. A synchronous active-high `rst` clears `result`, `spill`, `ovf` and `cond` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Word to be shifted |
| shamt_in | input | 64 | Shift operand; only bits [5:0] are used |
| fill_in | input | 64 | Word supplying the vacated bits |
| dir_right | input | 1 | 0 selects a left shift, 1 selects a right shift |
| rec_en | input | 1 | Write enable for the condition field |
| result | output | 64 | Merged, shifted word |
| spill | output | 64 | Bits shifted out of the source |
| ovf | output | 1 | Set when spill is nonzero |
| cond | output | 4 | Condition field: negative, positive, zero, overflow |

## Verification
The clocked properties sample the inputs on one edge and compare them with the outputs on the next. They rely on the inputs being held steady across each sampling edge and never being unknown while reset is low. The bench meets this by changing every input only on the falling edge. The combinational checks in the rotator and the merge stage skip their test while any operand is unknown, so the values present before reset do not trip them. The stimulus covers both directions at n=0, at n=63, and at a set of interior counts. It also drives shift operands whose upper bits are nonzero.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int WORD_W  = 64;
    localparam int SHAMT_W = $clog2(WORD_W);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [SHAMT_W-1:0] shamt_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

    // Condition field, packed MSB first as {neg, pos, zero, sum}.
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic sum;
    } cond_t;

    typedef struct packed {
        word_t result;
        word_t spill;
        logic  ovf;
    } fsh_res_t;

    // Rotate amount: n for a left shift, (W - n) mod W for a right shift.
    function automatic shamt_t rot_amount(input dir_e dir, input shamt_t n);
        shamt_t neg_n;
        neg_n = shamt_t'(~n + 1'b1);
        return (dir == DIR_RIGHT) ? neg_n : n;
    endfunction

    function automatic cond_t make_cond(input word_t res, input logic ovf);
        cond_t c;
        c.neg  = res[WORD_W-1];
        c.zero = (res == '0);
        c.pos  = !c.neg && !c.zero;
        c.sum  = ovf;
        return c;
    endfunction

endpackage

// File: rtl/fsh_rotator.sv
module fsh_rotator
    import fsh_pkg::*;
#(
    parameter int W   = WORD_W,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [AW+1];

    assign stg[0] = din;

    // Logarithmic rotate-left: stage k rotates by 2**k when amt[k] is set.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt[k] ? ((stg[k] << STEP) | (stg[k] >> (W - STEP)))
                                 : stg[k];
    end

    assign dout = stg[AW];

    // A rotation moves bits but never creates or drops them.
    always_comb begin
        if (!$isunknown({din, amt})) begin
            a_r2_rotate_keeps_popcount: assert ($countones(dout) == $countones(din));
        end
    end

endmodule

// File: rtl/fsh_mask_gen.sv
module fsh_mask_gen
    import fsh_pkg::*;
#(
    parameter int W   = WORD_W,
    localparam int AW = $clog2(W)
) (
    input  logic [AW-1:0] n,
    input  dir_e          dir,
    output logic [W-1:0]  mask
);

    // Positions are counted MSB first (position 0 is bit W-1). The left mask
    // spans positions 0..W-1-n and the right mask spans positions n..W-1.
    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam int POS = W - 1 - j;
        always_comb begin
            if (dir == DIR_RIGHT) mask[j] = (POS >= int'(n));
            else                  mask[j] = (POS <= (W - 1 - int'(n)));
        end
    end

endmodule

// File: rtl/fsh_merge.sv
module fsh_merge
    import fsh_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] rot,
    input  logic [W-1:0] fill,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res,
    output logic [W-1:0] spl,
    output logic         ovf
);

    assign res = (rot & mask) | (fill & ~mask);
    assign spl = rot & ~mask;
    assign ovf = |spl;

    always_comb begin
        if (!$isunknown({rot, fill, mask})) begin
            // Outside the mask, the result is the fill word; inside it, the rotated word.
            a_r2_fill_outside_mask: assert (((res ^ fill) & ~mask) == '0);
            a_r3_rot_inside_mask:   assert (((res ^ rot) & mask) == '0);
            a_r4_spill_disjoint:    assert ((spl & mask) == '0);
        end
    end

endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
    import fsh_pkg::*;
#(
    parameter int W   = WORD_W,
    localparam int AW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_in,
    input  logic [W-1:0] shamt_in,
    input  logic [W-1:0] fill_in,
    input  logic         dir_right,
    input  logic         rec_en,
    output logic [W-1:0] result,
    output logic [W-1:0] spill,
    output logic         ovf,
    output logic [3:0]   cond
);

    dir_e          dir;
    logic [AW-1:0] n;
    logic [AW-1:0] rot_amt;
    logic [W-1:0]  rot_w;
    logic [W-1:0]  mask_w;
    logic [W-1:0]  res_w;
    logic [W-1:0]  spl_w;
    logic          ovf_w;
    cond_t         cond_q;

    assign dir     = dir_e'(dir_right);
    assign n       = shamt_in[AW-1:0];
    assign rot_amt = rot_amount(dir, n);

    fsh_rotator #(.W(W)) u_rot (
        .din  (src_in),
        .amt  (rot_amt),
        .dout (rot_w)
    );

    fsh_mask_gen #(.W(W)) u_mask (
        .n    (n),
        .dir  (dir),
        .mask (mask_w)
    );

    fsh_merge #(.W(W)) u_merge (
        .rot  (rot_w),
        .fill (fill_in),
        .mask (mask_w),
        .res  (res_w),
        .spl  (spl_w),
        .ovf  (ovf_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            spill  <= '0;
            ovf    <= 1'b0;
            cond_q <= '0;
        end else begin
            result <= res_w;
            spill  <= spl_w;
            ovf    <= ovf_w;
            if (rec_en) cond_q <= make_cond(res_w, ovf_w);
        end
    end

    assign cond = cond_q;

    a_r5_ovf_tracks_spill: assert property (@(posedge clk) disable iff (rst)
        ovf == (spill != '0));

    a_r7_cond_held: assert property (@(posedge clk) disable iff (rst)
        !rec_en |=> $stable(cond));

    a_r6_one_class: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> ($countones(cond[3:1]) == 1) && (cond[0] == ovf));

    a_r8_zero_shift_passes: assert property (@(posedge clk) disable iff (rst)
        (shamt_in[AW-1:0] == '0) |=> (result == $past(src_in)) && (spill == '0));

    a_r2_left_low_fill: assert property (@(posedge clk) disable iff (rst)
        (!dir_right && shamt_in[AW-1:0] == AW'(W-1)) |=>
            (result[W-2:0] == $past(fill_in[W-2:0])) && (result[W-1] == $past(src_in[0])));

endmodule

// File: tb/fsh_funnel_test.sv
module fsh_funnel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_in = '0, shamt_in = '0, fill_in = '0;
    logic        dir_right = 1'b0, rec_en = 1'b0;
    logic [63:0] result, spill;
    logic        ovf;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fsh_funnel uut (
        .clk(clk), .rst(rst), .src_in(src_in), .shamt_in(shamt_in),
        .fill_in(fill_in), .dir_right(dir_right), .rec_en(rec_en),
        .result(result), .spill(spill), .ovf(ovf), .cond(cond)
    );

    localparam int NV = 10;
    localparam logic [63:0] VA [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_00FF, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000,
        64'h7FFF_0000_0000_0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1234_0000_0000_5678,
        64'hA5A5_5A5A_A5A5_5A5A };
    localparam logic [63:0] VB [NV] = '{
        64'd4, 64'd1, 64'd32, 64'd8, 64'd63,
        64'd17, 64'hFFFF_FFFF_FFFF_FF05, 64'd12, 64'd48, 64'd31 };
    localparam logic [63:0] VC [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1111_2222_3333_4444, 64'hAAAA_AAAA_AAAA_AAAA,
        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h0, 64'hCCCC_CCCC_CCCC_CCCC,
        64'h0123_4567_89AB_CDEF };
    localparam logic VD [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    // Reference built directly from the shift formulas in the requirements.
    function automatic logic [63:0] exp_res(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic d);
        int n = int'(b[5:0]);
        logic [63:0] ones = '1;
        if (n == 0) return a;
        if (!d) return (a << n) | (c & ((64'd1 << n) - 64'd1));
        return (a >> n) | (c & ~(ones >> n));
    endfunction

    function automatic logic [63:0] exp_spill(logic [63:0] a, logic [63:0] b, logic d);
        int n = int'(b[5:0]);
        if (n == 0) return '0;
        if (!d) return a >> (64 - n);
        return a << (64 - n);
    endfunction

    function automatic logic [3:0] exp_cond(logic [63:0] r, logic o);
        return {r[63], (!r[63] && r != 0), (r == 0), o};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic d, logic r);
        @(negedge clk);
        src_in = a; shamt_in = b; fill_in = c; dir_right = d; rec_en = r;
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(string tag, logic [63:0] a, logic [63:0] b, logic [63:0] c, logic d);
        logic [63:0] er, es;
        er = exp_res(a, b, c, d);
        es = exp_spill(a, b, d);
        apply(a, b, c, d, 1'b1);
        chk({tag, " R2/R3 result"}, result, er);
        chk({tag, " R4 spill"}, spill, es);
        chk({tag, " R5 ovf"}, {63'd0, ovf}, {63'd0, es != 0});
        chk({tag, " R6 cond"}, {60'd0, cond}, {60'd0, exp_cond(er, es != 0)});
    endtask

    initial begin
        #(4 * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset clears everything
        src_in = 64'hFFFF_FFFF_FFFF_FFFF; fill_in = '1; shamt_in = 64'd5; rec_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset result", result, '0);
        chk("R9 reset spill", spill, '0);
        chk("R9 reset ovf", {63'd0, ovf}, '0);
        chk("R9 reset cond", {60'd0, cond}, '0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec($sformatf("vec%0d", i), VA[i], VB[i], VC[i], VD[i]);

        // R2 left known value: n=4
        apply(64'h0123_4567_89AB_CDEF, 64'd4, 64'h0000_0000_0000_000A, 1'b0, 1'b1);
        chk("R2 left n=4", result, 64'h1234_5678_9ABC_DEFA);
        chk("R4 left n=4 spill", spill, 64'h0);
        // R3 right known value: n=8
        apply(64'h0123_4567_89AB_CDEF, 64'd8, 64'hAB00_0000_0000_0000, 1'b1, 1'b1);
        chk("R3 right n=8", result, 64'hAB01_2345_6789_ABCD);
        chk("R4 right n=8 spill", spill, 64'hEF00_0000_0000_0000);
        chk("R6 negative cond", {60'd0, cond}, 64'h9);

        // R8: n=0 in both directions (upper shamt bits set too: R1)
        apply(64'hDEAD_BEEF_0000_0001, 64'hABCD_0000_0000_0040, 64'hFFFF, 1'b1, 1'b0);
        chk("R8/R1 right n=0 result", result, 64'hDEAD_BEEF_0000_0001);
        chk("R8 right n=0 spill", spill, '0);
        apply(64'h0000_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFC0, 64'hFFFF, 1'b0, 1'b1);
        chk("R8/R1 left n=0 result", result, 64'h0000_BEEF_0000_0001);
        chk("R8 left n=0 ovf", {63'd0, ovf}, '0);
        chk("R6 positive cond", {60'd0, cond}, 64'h4);

        // R1: shift amount 63 both directions with junk upper bits
        run_vec("R1 left n=63", 64'h8000_0000_0000_0001, 64'h1234_5678_0000_00FF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
        run_vec("R1 right n=63", 64'h8000_0000_0000_0003, 64'hF0F0_0000_0000_003F, 64'h0, 1'b1);

        // R6 zero class, then R7 hold with rec_en low
        apply(64'h0, 64'd9, 64'h0, 1'b0, 1'b1);
        chk("R6 zero cond", {60'd0, cond}, 64'h2);
        apply(64'hFFFF_0000_0000_0000, 64'd4, 64'h0, 1'b0, 1'b0);
        chk("R7 cond held", {60'd0, cond}, 64'h2);
        chk("R5 ovf while not recording", {63'd0, ovf}, 64'h1);

        // R9: registered latency, output still shows previous op before edge
        @(negedge clk);
        src_in = 64'h1; shamt_in = 64'd1; fill_in = 64'h0; dir_right = 1'b0; rec_en = 1'b0;
        #1;
        chk("R9 latency before edge", result, 64'hFFF0_0000_0000_0000);
        @(posedge clk); #1;
        chk("R9 latency after edge", result, 64'h2);

        // R9: synchronous reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R9 mid reset result", result, '0);
        chk("R9 mid reset cond", {60'd0, cond}, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule